// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block sits on the host side of an 8-bit NAND flash device and erases one block for each request it accepts. A request carries a block number and is taken over a valid/ready handshake. The sequencer then drives the bus. It sends the erase-setup opcode, then the row address bytes, then the erase-confirm opcode. Each of these bytes is latched by the device on the rising edge of the active-low write strobe, with the command latch or the address latch enable marking what the byte is.

After the confirm opcode the device erases internally and signals this on its active-low ready/busy line. The sequencer first waits for the line to drop. It then waits for the line to rise again, bounding each wait with its own timeout. When the device is ready again, the sequencer issues the read-status opcode and performs one read strobe to capture the status byte. It then reports the outcome with a one-cycle done pulse and a two-bit result code. The ready/busy input is brought into the clock domain through two flops, and the external reset is released synchronously.

A block is 32 pages, so the block number sits above five page bits in the row address. The page bits are sent as zero because the device disregards them during an erase.

Top module: `nand_erase_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. The block number is captured at that edge, and `req_valid` and `req_block` are ignored until the next done pulse.
- R2: Each erase writes, in this order: opcode 60h with `nand_cle` high, the address bytes with `nand_ale` high, and opcode D0h with `nand_cle` high.
- R3: The row address is `{block, 5'b0}`, sent in three bytes least significant first. With default parameters these bytes are `{block[2:0],5'b0}`, then `block[10:3]`, then `{7'b0,block[11]}`.
- R4: `nand_cle` and `nand_ale` are never high together, and `nand_cle` is high only during command cycles. Whenever `nand_we_n` is low, one of the two latch enables is high and `nand_dq_oe` is high.
- R5: Each write strobe holds `nand_we_n` low for exactly WE_LOW_CLKS clocks, followed by WE_HIGH_CLKS clocks high with the latch enable and data held. The device latches the byte on the rising edge.
- R6: After the confirm opcode, if the synchronized ready/busy input does not go low within START_WAIT clocks, the erase ends with result 2'b11 (timeout). No status read is made.
- R7: Once busy is seen, if ready/busy stays low for BUSY_WAIT clocks, the erase ends with result 2'b11. No status read is made.
- R8: When the device is ready again, opcode 70h is written and then exactly one read strobe is made. During this strobe `nand_re_n` is low for WE_LOW_CLKS clocks and `nand_dq_oe` is low. `nand_dq_in` is sampled in the last low clock of the strobe.
- R9: Status bit 0 decides the result: 0 gives 2'b01 (pass) and 1 gives 2'b10 (fail). Status bits 7..1 have no effect on the result.
- R10: `done` is high for exactly one clock, carrying `result`. `req_ready` is high again on the following clock.
- R11: After reset `nand_we_n` and `nand_re_n` are high, `nand_cle`, `nand_ale`, `nand_dq_oe` and `done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_block | input | BLK_W | Block number to erase |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 01 pass, 10 fail, 11 timeout |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_out | output | 8 | Byte driven onto the I/O bus |
| nand_dq_oe | output | 1 | Output enable for the I/O bus |
| nand_dq_in | input | 8 | Byte read from the I/O bus |
| nand_rb_n | input | 1 | Device ready/busy, low while busy |

## Verification
Two functions of this block can act in the same clock: taking a new request and the completion of the erase in progress. A new request may already be waiting when the done pulse fires. The bench provokes this by holding `req_valid` high with a decoy block number through the whole erase. It judges the outcome by three observations: `req_ready` stays low on every clock until `done`, the captured address bytes belong to the first block, and `req_ready` returns exactly one clock after `done`. A second meeting point is the timeout counter expiring close to a ready/busy change. The bench covers this with a device that never goes busy and with one that never returns, and checks in both cases that no read strobe follows.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

  typedef enum logic [1:0] {
    CYC_CMD  = 2'd0,
    CYC_ADDR = 2'd1,
    CYC_READ = 2'd2
  } cyc_kind_e;

  typedef enum logic [1:0] {
    RES_NONE    = 2'b00,
    RES_PASS    = 2'b01,
    RES_FAIL    = 2'b10,
    RES_TIMEOUT = 2'b11
  } erase_res_e;

  localparam logic [7:0] OP_ERASE_SETUP   = 8'h60;
  localparam logic [7:0] OP_ERASE_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_READ_STATUS   = 8'h70;

endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_erase_pkg::*;
#(
  parameter int LOW_CLKS  = 2,
  parameter int HIGH_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  cyc_kind_e  kind,
  input  logic [7:0] wbyte,
  input  logic [7:0] rd_in,
  output logic       active,
  output logic       fin,
  output logic [7:0] rbyte,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] dq_out,
  output logic       dq_oe
);

  localparam int MAX_CLKS = (LOW_CLKS > HIGH_CLKS) ? LOW_CLKS : HIGH_CLKS;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_CLKS - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_CLKS - 1);

  logic             act_q, act_d;
  logic             hi_q, hi_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  cyc_kind_e        kind_q, kind_d;
  logic [7:0]       byte_q, byte_d;
  logic [7:0]       rbyte_q, rbyte_d;

  // Strobe phase: low for LOW_CLKS, then high for HIGH_CLKS with data held.
  always_comb begin
    act_d   = act_q;
    hi_d    = hi_q;
    cnt_d   = cnt_q;
    kind_d  = kind_q;
    byte_d  = byte_q;
    rbyte_d = rbyte_q;
    fin     = act_q && hi_q && (cnt_q == HIGH_LAST);
    if (!act_q) begin
      if (start) begin
        act_d  = 1'b1;
        hi_d   = 1'b0;
        cnt_d  = '0;
        kind_d = kind;
        byte_d = wbyte;
      end
    end else if (!hi_q) begin
      if (cnt_q == LOW_LAST) begin
        hi_d  = 1'b1;
        cnt_d = '0;
        if (kind_q == CYC_READ) rbyte_d = rd_in;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (fin) act_d = 1'b0;
      else     cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      hi_q    <= 1'b0;
      cnt_q   <= '0;
      kind_q  <= CYC_CMD;
      byte_q  <= '0;
      rbyte_q <= '0;
    end else begin
      act_q   <= act_d;
      hi_q    <= hi_d;
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
      byte_q  <= byte_d;
      rbyte_q <= rbyte_d;
    end
  end

  assign active = act_q;
  assign rbyte  = rbyte_q;
  assign cle    = act_q && (kind_q == CYC_CMD);
  assign ale    = act_q && (kind_q == CYC_ADDR);
  assign dq_oe  = act_q && (kind_q != CYC_READ);
  assign we_n   = !(act_q && !hi_q && (kind_q != CYC_READ));
  assign re_n   = !(act_q && !hi_q && (kind_q == CYC_READ));
  assign dq_out = byte_q;

  // R8: the read strobe and the write strobe never overlap
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  // R2: a new cycle is only requested while no cycle is running
  assert_start_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);

endmodule

// File: rtl/nand_busy_watch.sv
module nand_busy_watch #(
  parameter int START_WAIT = 32,
  parameter int BUSY_WAIT  = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_n_async,
  input  logic arm_low,
  input  logic arm_high,
  output logic low_seen,
  output logic high_seen,
  output logic expired
);

  localparam int LIM_MAX = (START_WAIT > BUSY_WAIT) ? START_WAIT : BUSY_WAIT;
  localparam int CW      = $clog2(LIM_MAX + 1);
  localparam logic [CW-1:0] START_LAST = CW'(START_WAIT - 1);
  localparam logic [CW-1:0] BUSY_LAST  = CW'(BUSY_WAIT - 1);

  logic [1:0]    rb_sync_q;
  logic          rb_s;
  logic [CW-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rb_sync_q <= 2'b11;
    else        rb_sync_q <= {rb_sync_q[0], rb_n_async};
  end
  assign rb_s = rb_sync_q[1];

  assign low_seen  = arm_low && !rb_s;
  assign high_seen = arm_high && rb_s;
  assign expired   = (arm_low && (cnt_q == START_LAST)) ||
                     (arm_high && (cnt_q == BUSY_LAST));

  always_comb begin
    cnt_d = cnt_q;
    if (!(arm_low || arm_high) || low_seen || high_seen) cnt_d = '0;
    else if (!expired)                                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: the two waits are never armed together
  assert_arm_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(arm_low && arm_high));

endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int BLK_W        = 12,
  parameter int PAGE_BITS    = 5,
  parameter int WE_LOW_CLKS  = 2,
  parameter int WE_HIGH_CLKS = 2,
  parameter int START_WAIT   = 32,
  parameter int BUSY_WAIT    = 400000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BLK_W-1:0] req_block,
  output logic             done,
  output logic [1:0]       result,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_out,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_in,
  input  logic             nand_rb_n
);

  localparam int ROW_W    = BLK_W + PAGE_BITS;
  localparam int ADDR_CYC = (ROW_W + 7) / 8;
  localparam int AIDX_W   = (ADDR_CYC > 1) ? $clog2(ADDR_CYC) : 1;
  localparam logic [AIDX_W-1:0] AIDX_LAST = AIDX_W'(ADDR_CYC - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_ADDR, ST_CONF, ST_WLOW,
    ST_WHIGH, ST_STAT, ST_READ, ST_DONE
  } seq_state_e;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign srst_n = rst_pipe_q[1];

  seq_state_e        state_q, state_d;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic [AIDX_W-1:0] aidx_q, aidx_d;
  erase_res_e        res_q, res_d;

  logic       drv_start, drv_active, drv_fin;
  cyc_kind_e  drv_kind;
  logic [7:0] drv_byte, drv_rbyte;
  logic       arm_low, arm_high, low_seen, high_seen, expired;

  logic [ADDR_CYC*8-1:0] row_pad;
  assign row_pad = (ADDR_CYC*8)'({blk_q, {PAGE_BITS{1'b0}}});

  always_comb begin
    state_d   = state_q;
    blk_d     = blk_q;
    aidx_d    = aidx_q;
    res_d     = res_q;
    drv_start = 1'b0;
    drv_kind  = CYC_CMD;
    drv_byte  = OP_ERASE_SETUP;
    arm_low   = 1'b0;
    arm_high  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          blk_d   = req_block;
          aidx_d  = '0;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        drv_start = !drv_active;
        if (drv_fin) state_d = ST_ADDR;
      end
      ST_ADDR: begin
        drv_start = !drv_active;
        drv_kind  = CYC_ADDR;
        drv_byte  = row_pad[{aidx_q, 3'b000} +: 8];
        if (drv_fin) begin
          if (aidx_q == AIDX_LAST) state_d = ST_CONF;
          else                     aidx_d  = aidx_q + 1'b1;
        end
      end
      ST_CONF: begin
        drv_start = !drv_active;
        drv_byte  = OP_ERASE_CONFIRM;
        if (drv_fin) state_d = ST_WLOW;
      end
      ST_WLOW: begin
        arm_low = 1'b1;
        if (low_seen) state_d = ST_WHIGH;
        else if (expired) begin
          res_d   = RES_TIMEOUT;
          state_d = ST_DONE;
        end
      end
      ST_WHIGH: begin
        arm_high = 1'b1;
        if (high_seen) state_d = ST_STAT;
        else if (expired) begin
          res_d   = RES_TIMEOUT;
          state_d = ST_DONE;
        end
      end
      ST_STAT: begin
        drv_start = !drv_active;
        drv_byte  = OP_READ_STATUS;
        if (drv_fin) state_d = ST_READ;
      end
      ST_READ: begin
        drv_start = !drv_active;
        drv_kind  = CYC_READ;
        if (drv_fin) begin
          res_d   = drv_rbyte[0] ? RES_FAIL : RES_PASS;
          state_d = ST_DONE;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      blk_q   <= '0;
      aidx_q  <= '0;
      res_q   <= RES_NONE;
    end else begin
      state_q <= state_d;
      blk_q   <= blk_d;
      aidx_q  <= aidx_d;
      res_q   <= res_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign result    = res_q;

  nand_bus_cycle #(
    .LOW_CLKS  (WE_LOW_CLKS),
    .HIGH_CLKS (WE_HIGH_CLKS)
  ) u_cycle (
    .clk    (clk),
    .rst_n  (srst_n),
    .start  (drv_start),
    .kind   (drv_kind),
    .wbyte  (drv_byte),
    .rd_in  (nand_dq_in),
    .active (drv_active),
    .fin    (drv_fin),
    .rbyte  (drv_rbyte),
    .cle    (nand_cle),
    .ale    (nand_ale),
    .we_n   (nand_we_n),
    .re_n   (nand_re_n),
    .dq_out (nand_dq_out),
    .dq_oe  (nand_dq_oe)
  );

  nand_busy_watch #(
    .START_WAIT (START_WAIT),
    .BUSY_WAIT  (BUSY_WAIT)
  ) u_watch (
    .clk        (clk),
    .rst_n      (srst_n),
    .rb_n_async (nand_rb_n),
    .arm_low    (arm_low),
    .arm_high   (arm_high),
    .low_seen   (low_seen),
    .high_seen  (high_seen),
    .expired    (expired)
  );

  assert_latch_excl_R4: assert property (@(posedge clk) disable iff (!srst_n)
    !(nand_cle && nand_ale));

  assert_we_qualified_R4: assert property (@(posedge clk) disable iff (!srst_n)
    !nand_we_n |-> ((nand_cle || nand_ale) && nand_dq_oe));

  assert_accept_drops_ready_R1: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!srst_n)
    done |=> (!done && req_ready));

  assert_result_coded_R9: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> (result != 2'b00));

  assert_idle_bus_quiet_R11: assert property (@(posedge clk) disable iff (!srst_n)
    req_ready |-> (nand_we_n && nand_re_n && !nand_dq_oe));

endmodule

// File: tb/nand_erase_seq_bench.sv
module nand_erase_seq_bench;

  localparam int WE_LOW  = 2;
  localparam int WE_HIGH = 2;
  localparam int T_START = 16;
  localparam int T_BUSY  = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [11:0] req_block;
  logic       done;
  logic [1:0] result;
  logic       nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] nand_dq_out;
  logic [7:0] nand_dq_in;
  logic       nand_rb_n;

  always #4 clk = ~clk;

  nand_erase_seq #(
    .BLK_W(12), .PAGE_BITS(5), .WE_LOW_CLKS(WE_LOW), .WE_HIGH_CLKS(WE_HIGH),
    .START_WAIT(T_START), .BUSY_WAIT(T_BUSY)
  ) u_nand_erase_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_block(req_block), .done(done), .result(result),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
  );

  int checks = 0, errors = 0;
  int m_checks = 0, m_errors = 0;
  bit finished = 0;

  // test configuration, written only by the main process
  logic [7:0] cfg_status = 8'h00;
  int  cfg_dly = 0, cfg_hold = 0;
  bit  cfg_no_low = 0, cfg_release = 0, cfg_clear = 0, mon_on = 0, op_busy = 0;

  // monitor and device model state, written only by the monitor process
  logic [9:0] lat_q[$];
  int  reads = 0, we_lo = 0, re_lo = 0, dev_phase = 0, dev_cnt = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_m(input bit ok, input string req, input int act, input int exp);
    m_checks++;
    if (!ok) begin
      m_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock behavioural model of the bus and of the device, sampled at negedge.
  initial nand_rb_n = 1'b1;
  initial nand_dq_in = 8'h5A;
  always @(negedge clk) begin
    if (cfg_clear) begin
      lat_q.delete();
      reads = 0;
    end
    if (mon_on) begin
      chk_m(!(nand_cle && nand_ale), "R4 cle/ale exclusive", {nand_cle, nand_ale}, 0);
      if (op_busy) chk_m(!req_ready, "R1 ready low during erase", req_ready, 0);
      if (!nand_we_n) begin
        we_lo++;
        chk_m((nand_cle || nand_ale) && nand_dq_oe, "R4 strobe qualified",
              {nand_cle, nand_ale, nand_dq_oe}, 1);
      end else if (!prev_we) begin
        chk_m(we_lo == WE_LOW, "R5 we_n low width", we_lo, WE_LOW);
        lat_q.push_back({nand_cle, nand_ale, nand_dq_out});
        if (nand_cle && nand_dq_out == 8'hD0 && !cfg_no_low) begin
          dev_phase = 1;
          dev_cnt = cfg_dly;
        end
        we_lo = 0;
      end
      if (!nand_re_n) begin
        re_lo++;
        chk_m(!nand_dq_oe, "R8 bus released on read", nand_dq_oe, 0);
      end else if (!prev_re) begin
        chk_m(re_lo == WE_LOW, "R8 re_n low width", re_lo, WE_LOW);
        chk_m(lat_q.size() == 6 && lat_q[lat_q.size()-1] == {2'b10, 8'h70},
              "R8 read follows 70h", lat_q.size(), 6);
        reads++;
        re_lo = 0;
      end
      prev_we = nand_we_n;
      prev_re = nand_re_n;
    end
    // device: busy after confirm
    if (cfg_release) begin
      dev_phase = 0;
      nand_rb_n = 1'b1;
    end else if (dev_phase == 1) begin
      if (dev_cnt == 0) begin
        nand_rb_n = 1'b0;
        dev_phase = 2;
        dev_cnt = cfg_hold;
      end else dev_cnt--;
    end else if (dev_phase == 2) begin
      if (cfg_hold >= 0) begin
        if (dev_cnt == 0) begin
          nand_rb_n = 1'b1;
          dev_phase = 0;
        end else dev_cnt--;
      end
    end
    nand_dq_in = nand_re_n ? 8'h5A : cfg_status;
  end

  task automatic run_erase(input logic [11:0] blk, input logic [7:0] st,
                           input int dly, input int hold, input bit no_low,
                           input logic [1:0] exp_res, input string tag);
    int nbytes;
    bit seen;
    logic [7:0] eb [5];
    @(negedge clk);
    cfg_status = st; cfg_dly = dly; cfg_hold = hold; cfg_no_low = no_low;
    cfg_release = 0; cfg_clear = 1;
    @(negedge clk);
    cfg_clear = 0;
    chk(req_ready, "R1 idle ready", req_ready, 1);
    req_valid = 1'b1;
    req_block = blk;
    @(negedge clk);
    chk(!req_ready, "R1 request taken", req_ready, 0);
    op_busy = 1;
    req_block = ~blk;  // decoy held with valid high, must be ignored
    seen = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    op_busy = 0;
    req_valid = 1'b0;
    chk(seen, "R10 done pulse seen", seen, 1);
    chk(result == exp_res, tag, result, exp_res);
    @(negedge clk);
    chk(!done && req_ready, "R10 single pulse, ready back", {done, req_ready}, 1);
    nbytes = (exp_res == 2'b11) ? 5 : 6;
    chk(lat_q.size() == nbytes, "R2 byte count", lat_q.size(), nbytes);
    chk(reads == ((exp_res == 2'b11) ? 0 : 1), "R6 R7 R8 read count", reads,
        (exp_res == 2'b11) ? 0 : 1);
    eb[0] = 8'h60;
    eb[1] = {blk[2:0], 5'b0};
    eb[2] = blk[10:3];
    eb[3] = {7'b0, blk[11]};
    eb[4] = 8'hD0;
    if (lat_q.size() >= 5) begin
      chk(lat_q[0] == {2'b10, eb[0]}, "R2 setup opcode", lat_q[0], {2'b10, eb[0]});
      for (int k = 1; k < 4; k++)
        chk(lat_q[k] == {2'b01, eb[k]}, "R3 address byte", lat_q[k], {2'b01, eb[k]});
      chk(lat_q[4] == {2'b10, eb[4]}, "R2 confirm opcode", lat_q[4], {2'b10, eb[4]});
    end
    cfg_release = 1;
    repeat (4) @(negedge clk);
    cfg_release = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks + m_checks, errors + m_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_block = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(nand_we_n && nand_re_n, "R11 strobes idle", {nand_we_n, nand_re_n}, 3);
    chk(!nand_cle && !nand_ale && !nand_dq_oe, "R11 latches idle",
        {nand_cle, nand_ale, nand_dq_oe}, 0);
    chk(!done && req_ready, "R11 handshake idle", {done, req_ready}, 1);
    mon_on = 1;
    run_erase(12'h000, 8'hE0, 3, 30, 0, 2'b01, "R9 pass, high bits set");
    run_erase(12'hFFF, 8'h01, 3, 30, 0, 2'b10, "R9 fail on bit 0");
    run_erase(12'hA5C, 8'hFE, 2, 20, 0, 2'b01, "R9 pass with bits 7..1 set");
    run_erase(12'h801, 8'hE1, 5, 40, 0, 2'b10, "R9 fail with other bits");
    run_erase(12'h3C6, 8'h00, 0, 0, 1, 2'b11, "R6 timeout, never busy");
    run_erase(12'h5A5, 8'h00, 1, -1, 0, 2'b11, "R7 timeout, stuck busy");
    run_erase(12'h123, 8'h00, 0, 4, 0, 2'b01, "R9 pass after timeouts, short busy");
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks + m_checks, errors + m_errors);
      $finish;
    end
  end

endmodule